// File: doc/BRIEF.md
# Isolated Link Output Enable and Startup Controller

This block drives the receive side of a one-way isolated multi-channel data link. The recovered channel bits arrive on `rx_data`. The block turns them into per-channel output values (`ch_out`) and one shared drive control (`ch_drive`, where 1 means the pads drive and 0 means high impedance). Each side of the link reports its supply health as a digital flag. For each flag, the block keeps its own lockout timer that counts clock cycles, so each side leaves lockout on its own schedule.

While the output side is locked out, the pads drive low. After lockout ends, an enable input decides the output state. When enable is low, the pads float. When enable is high and the input side is still in lockout, the pads drive a fail-safe low. When enable is high and both sides are out of lockout, the pads carry the recovered data. A pad-status input reports when the enable pin is not connected, and an unconnected pin counts as enabled. A build parameter removes the enable pin entirely. The channel count is a parameter, and every lane above it always reads low.

Top module: `iso_out_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, `ch_drive` is 1 and `ch_out` is all zeros until the startup rules below allow data through.
- R2: `ch_out` first carries `rx_data` (lanes below `N_CH`) on the `STARTUP_CYCLES+1`-th rising edge at which `out_pwr_ok` has been sampled high without a break, provided enable is asserted and the input side is ready. Until then, `ch_drive`=1 and `ch_out`=0. After that, `ch_out` tracks `rx_data` with one cycle of latency.
- R3: Any cycle with `out_pwr_ok` low restarts the output-side timer from zero. Outputs return to driven low on the second edge after the drop, and the full interval must elapse again once the flag returns.
- R4: After output-side lockout, enable low gives `ch_drive`=0 and `ch_out`=0, whatever the data and the input-side supply state. Enable passes through two synchronizer flops, so a change sampled at edge k reaches the pins at edge k+2.
- R5: While `en_float`=1 (pin unconnected), enable counts as asserted whatever the value of `en_level`.
- R6: With the output side ready and enable asserted, while the input side is in lockout the block drives `ch_drive`=1 and `ch_out`=0. A drop of `in_pwr_ok` shows at the pins on the second edge.
- R7: The input side has its own timer, driven by `in_pwr_ok`. Input-side lockout never changes the output side's lockout or its high-impedance state. After `in_pwr_ok` returns, data passes again on the `STARTUP_CYCLES+1`-th high edge.
- R8: If the output side powers up with enable low, the pins drive low during lockout and switch to high impedance (`ch_drive`=0) on the edge after the interval completes.
- R9: With `HAS_ENABLE`=0, `en_level` and `en_float` have no effect, and the block acts as if enable were always asserted.
- R10: `ch_out` lanes at index `N_CH` and above are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_pwr_ok | input | 1 | Supply-good flag of the input (transmit) side |
| out_pwr_ok | input | 1 | Supply-good flag of the output (receive) side |
| en_level | input | 1 | Level read on the enable pin, active high |
| en_float | input | 1 | 1 when the enable pin is unconnected (weak pull-up) |
| rx_data | input | MAX_CH | Recovered channel data |
| ch_out | output | MAX_CH | Per-channel output values |
| ch_drive | output | 1 | 1 = drive pads, 0 = high impedance |

## Verification
Each supply-flag transition reaches the pins on a fixed count of edges. A flag drop shows on the second edge. A restored flag passes data on edge `STARTUP_CYCLES+1`, and the bench checks one edge earlier as well as on that edge. An enable change passes the synchronizer and appears at the pins on the third edge after it is driven, and the bench checks both the second and the third edge. Plain data changes appear after one edge. All inputs are driven and all outputs sampled on falling edges, with tick counts chosen to land on these edges, so every check sits on the exact cycle where a value becomes due.

// File: rtl/iso_pkg.sv
package iso_pkg;

  // Output behaviour selected from the three qualifying conditions.
  typedef enum logic [1:0] {
    MODE_LOCK = 2'd0,  // output side in lockout: drive low
    MODE_HIZ  = 2'd1,  // disabled: float pads
    MODE_SAFE = 2'd2,  // far side in lockout: fail-safe low
    MODE_PASS = 2'd3   // pass recovered data
  } out_mode_e;

  function automatic out_mode_e pick_mode(input logic out_ready,
                                          input logic enabled,
                                          input logic in_ready);
    if (!out_ready)     return MODE_LOCK;
    else if (!enabled)  return MODE_HIZ;
    else if (!in_ready) return MODE_SAFE;
    else                return MODE_PASS;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

endpackage

// File: rtl/lockout_timer.sv
module lockout_timer #(
  parameter int unsigned CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic ready
);
  localparam int unsigned CNT_W = iso_pkg::cnt_width(CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!pwr_ok) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/enable_sync.sv
module enable_sync #(
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_level,
  input  logic en_float,
  output logic en_s
);
  generate
    if (HAS_ENABLE) begin : g_pin
      logic en_raw;
      logic [1:0] sync_q;
      assign en_raw = en_level | en_float;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], en_raw};
      end
      assign en_s = sync_q[1];
    end else begin : g_nopin
      logic unused_pin;
      assign unused_pin = ^{clk, rst_n, en_level, en_float};
      assign en_s = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned MAX_CH = 6,
  parameter int unsigned N_CH   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  iso_pkg::out_mode_e   mode,
  input  logic [MAX_CH-1:0]    rx_data,
  output logic [MAX_CH-1:0]    ch_out,
  output logic                 ch_drive
);
  import iso_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_drive <= 1'b1;
    else        ch_drive <= (mode != MODE_HIZ);
  end

  generate
    for (genvar g = 0; g < MAX_CH; g++) begin : g_lane
      if (g < N_CH) begin : g_live
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ch_out[g] <= 1'b0;
          else        ch_out[g] <= (mode == MODE_PASS) & rx_data[g];
        end
      end else begin : g_tied
        logic unused_bit;
        assign unused_bit = rx_data[g];
        assign ch_out[g]  = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/iso_out_ctrl.sv
module iso_out_ctrl #(
  parameter int unsigned MAX_CH         = 6,
  parameter int unsigned N_CH           = 6,
  parameter int unsigned STARTUP_CYCLES = 10000,
  parameter bit          HAS_ENABLE     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_pwr_ok,
  input  logic              out_pwr_ok,
  input  logic              en_level,
  input  logic              en_float,
  input  logic [MAX_CH-1:0] rx_data,
  output logic [MAX_CH-1:0] ch_out,
  output logic              ch_drive
);
  import iso_pkg::*;

  // Named internal events, observed by the bound checker.
  logic      out_rdy;
  logic      in_rdy;
  logic      en_s;
  out_mode_e mode;

  lockout_timer #(.CYCLES(STARTUP_CYCLES)) u_out_tmr (
    .clk(clk), .rst_n(rst_n), .pwr_ok(out_pwr_ok), .ready(out_rdy));

  lockout_timer #(.CYCLES(STARTUP_CYCLES)) u_in_tmr (
    .clk(clk), .rst_n(rst_n), .pwr_ok(in_pwr_ok), .ready(in_rdy));

  enable_sync #(.HAS_ENABLE(HAS_ENABLE)) u_en (
    .clk(clk), .rst_n(rst_n), .en_level(en_level),
    .en_float(en_float), .en_s(en_s));

  assign mode = pick_mode(out_rdy, en_s, in_rdy);

  out_stage #(.MAX_CH(MAX_CH), .N_CH(N_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rx_data(rx_data),
    .ch_out(ch_out), .ch_drive(ch_drive));
endmodule

// File: rtl/iso_out_ctrl_chk.sv
module iso_out_ctrl_chk #(
  parameter int unsigned MAX_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_pwr_ok,
  input logic              out_rdy,
  input logic              in_rdy,
  input logic              en_s,
  input logic [MAX_CH-1:0] ch_out,
  input logic              ch_drive
);
  p_lock_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |=> (ch_drive && ch_out == '0));

  p_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && !en_s) |=> (!ch_drive && ch_out == '0));

  p_failsafe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && en_s && !in_rdy) |=> (ch_drive && ch_out == '0));

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_pwr_ok |=> !out_rdy);

  p_drive_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_drive) |-> $past(!en_s));

  p_ready_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> $past(out_pwr_ok));
endmodule

bind iso_out_ctrl iso_out_ctrl_chk #(.MAX_CH(MAX_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_pwr_ok(out_pwr_ok), .out_rdy(out_rdy),
  .in_rdy(in_rdy), .en_s(en_s), .ch_out(ch_out), .ch_drive(ch_drive));

// File: tb/iso_out_ctrl_bench.sv
module iso_out_ctrl_bench;
  localparam int S  = 16;
  localparam int MX = 6;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_ok = 1'b0, out_ok = 1'b0, en_lv = 1'b1, en_fl = 1'b0;
  logic [MX-1:0] rx = '0;
  logic [MX-1:0] q, q2;
  logic drv, drv2;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iso_out_ctrl #(.MAX_CH(MX), .N_CH(NC), .STARTUP_CYCLES(S), .HAS_ENABLE(1'b1))
    u_iso_out_ctrl (.clk(clk), .rst_n(rst_n), .in_pwr_ok(in_ok), .out_pwr_ok(out_ok),
      .en_level(en_lv), .en_float(en_fl), .rx_data(rx), .ch_out(q), .ch_drive(drv));

  iso_out_ctrl #(.MAX_CH(MX), .N_CH(NC), .STARTUP_CYCLES(S), .HAS_ENABLE(1'b0))
    u_noen (.clk(clk), .rst_n(rst_n), .in_pwr_ok(in_ok), .out_pwr_ok(out_ok),
      .en_level(en_lv), .en_float(en_fl), .rx_data(rx), .ch_out(q2), .ch_drive(drv2));

  // Expected pins: {drive, data masked to live lanes}.
  function automatic logic [MX:0] want(input logic d, input logic [MX-1:0] v);
    return {d, v & MX'((1 << NC) - 1)};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [MX:0] act, input logic [MX:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got drive/data %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    tick(2);
    chk("R1 reset", {drv, q}, want(1, 0));
    rst_n = 1'b1;
    tick(1);
    chk("R1 after release", {drv, q}, want(1, 0));
  endtask

  task automatic t_powerup;
    rx = 6'h2D; in_ok = 1; out_ok = 1;
    tick(S);
    chk("R2 held low at interval end", {drv, q}, want(1, 0));
    tick(1);
    chk("R2 data follows", {drv, q}, want(1, 6'h2D));
  endtask

  task automatic t_patterns;
    logic [MX-1:0] pats [4] = '{6'h3F, 6'h00, 6'h15, 6'h2A};
    foreach (pats[i]) begin
      rx = pats[i];
      tick(1);
      chk("R2 pattern", {drv, q}, want(1, pats[i]));
    end
    rx = 6'h3F; tick(1);
    chk("R10 upper lanes low", {1'b0, q[MX-1:NC], {NC{1'b0}}}, '0);
  endtask

  task automatic t_disable;
    rx = 6'h09; en_lv = 0;
    tick(2);
    chk("R4 before sync", {drv, q}, want(1, 6'h09));
    tick(1);
    chk("R4 hiz", {drv, q}, want(0, 0));
    rx = 6'h06; tick(1);
    chk("R4 hiz data ignored", {drv, q}, want(0, 0));
    chk("R9 no pin follows", {drv2, q2}, want(1, 6'h06));
    in_ok = 0; tick(2);
    chk("R4 hiz with input unpowered", {drv, q}, want(0, 0));
    chk("R6 no pin fail-safe", {drv2, q2}, want(1, 0));
    in_ok = 1; tick(S);
    chk("R7 output side stays hiz", {drv, q}, want(0, 0));
    tick(1);
    chk("R7 no pin resumes", {drv2, q2}, want(1, 6'h06));
  endtask

  task automatic t_float;
    en_fl = 1; tick(3);
    chk("R5 floating enable active", {drv, q}, want(1, 6'h06));
    en_fl = 0; tick(3);
    chk("R5 driven low disables", {drv, q}, want(0, 0));
    en_lv = 1; tick(3);
    chk("R4 re-enable", {drv, q}, want(1, 6'h06));
  endtask

  task automatic t_failsafe;
    rx = 6'h0F; in_ok = 0; tick(2);
    chk("R6 fail-safe low", {drv, q}, want(1, 0));
    in_ok = 1; tick(S);
    chk("R7 input side own interval", {drv, q}, want(1, 0));
    tick(1);
    chk("R7 data after input interval", {drv, q}, want(1, 6'h0F));
  endtask

  task automatic t_restart;
    out_ok = 0; tick(1); out_ok = 1; tick(S / 2);
    chk("R3 low mid interval", {drv, q}, want(1, 0));
    out_ok = 0; tick(1); out_ok = 1;
    tick(S);
    chk("R3 full interval again", {drv, q}, want(1, 0));
    tick(1);
    chk("R3 data after restart", {drv, q}, want(1, 6'h0F));
  endtask

  task automatic t_en_low_powerup;
    en_lv = 0; tick(3);
    chk("R8 disabled", {drv, q}, want(0, 0));
    out_ok = 0; tick(2);
    chk("R8 lockout drives low", {drv, q}, want(1, 0));
    out_ok = 1; tick(S);
    chk("R8 still low at interval end", {drv, q}, want(1, 0));
    tick(1);
    chk("R8 hiz after interval", {drv, q}, want(0, 0));
    chk("R9 no pin passes data", {drv2, q2}, want(1, 6'h0F));
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_patterns();
    t_disable();
    t_float();
    t_failsafe();
    t_restart();
    t_en_low_powerup();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule